// File: doc/BRIEF.md
# Floating-Point Compare, Min/Max and Classify Unit

This unit handles the non-arithmetic floating-point operations of a scalar pipeline. It takes two 64-bit operand buses, a format bit and a three-bit operation code. It can perform three ordered or equality comparisons, a minimum or maximum selection, or a ten-way class test. Single-precision operands are taken from the low 32 bits of each bus, and any upper bits are ignored.

The unit contains one register stage. When `in_valid` is high at a clock edge, the result and the invalid-operation flag are captured at that edge, and `out_valid` goes high for the next cycle. Comparison results are 0 or 1. Min/max results are the selected floating-point value. A class result is a one-hot mask. Every result is zero-extended to 64 bits.

Top module: `fp_cmp_unit`

## Requirements
- R1: A request with `in_valid` high shows `out_valid` high in the next cycle, with its result and flag. When `in_valid` is low, `out_valid` falls and `result`/`invalid` keep their previous values. The `op_sel` codes are 0 = less-or-equal, 1 = less-than, 2 = equal, 3 = minimum, 4 = maximum and 5 = classify. Codes 6 and 7 give result 0 and no flag.
- R2: Less-than, less-or-equal and equal give 1 or 0 according to numeric order. This holds for negative, positive and infinite values in both formats.
- R3: Less-than and less-or-equal return 0 and raise `invalid` when either operand is any NaN.
- R4: Equal returns 0 when either operand is a NaN. It raises `invalid` only when an operand is a signaling NaN.
- R5: Negative zero and positive zero compare equal. Less-than between them is 0, and less-or-equal is 1.
- R6: For min/max, a signaling NaN in operand B returns operand A. Otherwise, a signaling NaN in operand A returns operand B. Both cases raise `invalid`.
- R7: For min/max with one quiet NaN and no signaling NaN, the non-NaN operand is returned and no flag is raised.
- R8: For min/max with two quiet NaNs, the canonical quiet NaN is returned. This is 0x7FC00000 in single format and 0x7FF8000000000000 in double format.
- R9: Min/max return the smaller or larger value. The minimum of the two zeros is negative zero, and the maximum is positive zero.
- R10: Classify sets exactly one bit of `result[9:0]` and never raises `invalid`. The bits are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. A NaN has an all-ones exponent and a nonzero fraction, and it is quiet when the fraction MSB is 1.
- R11: With `is_double` low, operand bits 63:32 have no effect, and single-format results have bits 63:32 equal to zero.
- R12: While `rst_n` is low, `out_valid`, `result` and `invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| is_double | input | 1 | 1 = double format, 0 = single (low 32 bits) |
| op_sel | input | 3 | Operation code (see R1) |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Integer or floating-point result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The properties assume that `op_sel` and `is_double` are stable only while `in_valid` is high. They also assume that every output check refers to the previous cycle's request. The stimulus changes all inputs only at the falling clock edge, and it lowers `in_valid` between requests so that each request is captured exactly once. Operand patterns cover NaN payloads in both quiet and signaling forms, subnormals, both zeros and infinities. In single format, some operands carry non-zero upper halves.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int CLASS_W   = 10;

  typedef enum logic [2:0] {
    OP_LE    = 3'd0,
    OP_LT    = 3'd1,
    OP_EQ    = 3'd2,
    OP_MIN   = 3'd3,
    OP_MAX   = 3'd4,
    OP_CLASS = 3'd5
  } fop_e;

  typedef struct packed {
    logic               sign;
    logic               nan;
    logic               snan;
    logic               zero;
    logic [CLASS_W-1:0] mask;
  } fp_info_t;
endpackage

// File: rtl/fp_operand_class.sv
module fp_operand_class
  import fp_cmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fp_info_t              info
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero, frac_zero, is_inf, is_sub, is_norm;

  assign expo      = val[EXP_W+FRAC_W-1:FRAC_W];
  assign frac      = val[FRAC_W-1:0];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;
  assign is_inf    = exp_ones & frac_zero;
  assign is_sub    = exp_zero & ~frac_zero;
  assign is_norm   = ~exp_ones & ~exp_zero;

  always_comb begin
    info.sign = val[EXP_W+FRAC_W];
    info.nan  = exp_ones & ~frac_zero;
    info.snan = info.nan & ~frac[FRAC_W-1];
    info.zero = exp_zero & frac_zero;
    info.mask = '0;
    info.mask[0] = is_inf & info.sign;
    info.mask[1] = is_norm & info.sign;
    info.mask[2] = is_sub & info.sign;
    info.mask[3] = info.zero & info.sign;
    info.mask[4] = info.zero & ~info.sign;
    info.mask[5] = is_sub & ~info.sign;
    info.mask[6] = is_norm & ~info.sign;
    info.mask[7] = is_inf & ~info.sign;
    info.mask[8] = info.snan;
    info.mask[9] = info.nan & frac[FRAC_W-1];
  end
endmodule

// File: rtl/fp_order_cmp.sv
module fp_order_cmp #(
  parameter int MAG_W = 64
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             both_zero,
  output logic             lt,
  output logic             eq
);
  logic mag_lt, mag_eq;
  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    eq = both_zero | ((sign_a == sign_b) & mag_eq);
    if (both_zero)             lt = 1'b0;
    else if (sign_a != sign_b) lt = sign_a;
    else if (sign_a)           lt = ~mag_lt & ~mag_eq;
    else                       lt = mag_lt;
  end
endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
  import fp_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  fp_info_t          info_a,
  input  fp_info_t          info_b,
  input  logic              a_lt_b,
  input  logic              pick_max,
  input  logic              is_double,
  output logic [DATA_W-1:0] sel,
  output logic              inv
);
  logic [DATA_W-1:0] canon;
  assign canon = is_double ? {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DATA_W-DP_EXP_W-2){1'b0}}}
                           : {{(DATA_W-32){1'b0}}, 1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};

  always_comb begin
    inv = info_a.snan | info_b.snan;
    if (info_b.snan)                    sel = val_a;
    else if (info_a.snan)               sel = val_b;
    else if (info_a.nan & info_b.nan)   sel = canon;
    else if (info_a.nan)                sel = val_b;
    else if (info_b.nan)                sel = val_a;
    else if (info_a.zero & info_b.zero) sel = (info_a.sign ^ pick_max) ? val_a : val_b;
    else                                sel = (a_lt_b ^ pick_max) ? val_a : val_b;
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fp_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_double,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              invalid
);
  localparam int SP_W = SP_EXP_W + SP_FRAC_W + 1;

  logic [DATA_W-1:0] opnd [2];
  logic [DATA_W-1:0] val  [2];
  logic [DATA_W-1:0] mag  [2];
  fp_info_t          info [2];

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    fp_info_t sp_info, dp_info;
    fp_operand_class #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .val (opnd[i][SP_W-1:0]),
      .info(sp_info)
    );
    fp_operand_class #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .val (opnd[i]),
      .info(dp_info)
    );
    assign info[i] = is_double ? dp_info : sp_info;
    assign val[i]  = is_double ? opnd[i] : {{(DATA_W-SP_W){1'b0}}, opnd[i][SP_W-1:0]};
    assign mag[i]  = is_double ? {1'b0, opnd[i][DATA_W-2:0]}
                               : {{(DATA_W-SP_W+1){1'b0}}, opnd[i][SP_W-2:0]};
  end

  logic a_lt_b, a_eq_b;
  fp_order_cmp #(.MAG_W(DATA_W)) u_cmp (
    .sign_a   (info[0].sign),
    .sign_b   (info[1].sign),
    .mag_a    (mag[0]),
    .mag_b    (mag[1]),
    .both_zero(info[0].zero & info[1].zero),
    .lt       (a_lt_b),
    .eq       (a_eq_b)
  );

  fop_e              op;
  logic [DATA_W-1:0] mm_sel;
  logic              mm_inv;
  assign op = fop_e'(op_sel);

  fp_minmax_sel #(.DATA_W(DATA_W)) u_mm (
    .val_a    (val[0]),
    .val_b    (val[1]),
    .info_a   (info[0]),
    .info_b   (info[1]),
    .a_lt_b   (a_lt_b),
    .pick_max (op == OP_MAX),
    .is_double(is_double),
    .sel      (mm_sel),
    .inv      (mm_inv)
  );

  logic              any_nan, any_snan;
  logic [DATA_W-1:0] res_nxt;
  logic              inv_nxt;
  assign any_nan  = info[0].nan | info[1].nan;
  assign any_snan = info[0].snan | info[1].snan;

  always_comb begin
    res_nxt = '0;
    inv_nxt = 1'b0;
    case (op)
      OP_LE: begin
        res_nxt[0] = ~any_nan & (a_lt_b | a_eq_b);
        inv_nxt    = any_nan;
      end
      OP_LT: begin
        res_nxt[0] = ~any_nan & a_lt_b;
        inv_nxt    = any_nan;
      end
      OP_EQ: begin
        res_nxt[0] = ~any_nan & a_eq_b;
        inv_nxt    = any_snan;
      end
      OP_MIN, OP_MAX: begin
        res_nxt = mm_sel;
        inv_nxt = mm_inv;
      end
      OP_CLASS: res_nxt[CLASS_W-1:0] = info[0].mask;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_nxt;
        invalid <= inv_nxt;
      end
    end
  end
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              invalid
);
  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid)));
  // R2
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel <= 3'd2) |=> (result[DATA_W-1:1] == '0));
  // R10
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5) |=> ($countones(result[9:0]) == 1 && result[DATA_W-1:10] == '0));
  // R10
  class_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5) |=> !invalid);
endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .out_valid(out_valid),
  .result   (result),
  .invalid  (invalid)
);

// File: tb/fp_cmp_unit_bench.sv
module fp_cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        is_double;
  logic [2:0]  op_sel;
  logic [63:0] opnd_a, opnd_b;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;

  always #10 clk = ~clk;

  fp_cmp_unit u_fp_cmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_double(is_double),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  typedef struct {
    logic [63:0] res;
    logic        inv;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  localparam logic [2:0] LE = 3'd0, LT = 3'd1, EQ = 3'd2, MN = 3'd3, MX = 3'd4, CL = 3'd5;

  task automatic drive(input logic [2:0] op, input logic dbl, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] er, input logic ei,
                       input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; is_double = dbl; opnd_a = a; opnd_b = b;
    e.res = er; e.inv = ei; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected out_valid: act %h exp none", result);
      end else begin
        e = sb_q.pop_front();
        if (result !== e.res || invalid !== e.inv) begin
          errors++;
          $display("FAIL %s: act res=%h inv=%b exp res=%h inv=%b", e.req, result, invalid, e.res, e.inv);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; is_double = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: act v=%b r=%h i=%b exp 0 0 0", out_valid, result, invalid);
    end
    rst_n = 1'b1;
    // R2 ordering
    drive(LT, 0, 64'h3F800000, 64'h40000000, 64'd1, 0, "R2 lt s 1<2");
    drive(LT, 0, 64'hC0000000, 64'hBF800000, 64'd1, 0, "R2 lt s -2<-1");
    drive(LE, 0, 64'h40000000, 64'h3F800000, 64'd0, 0, "R2 le s 2<=1");
    drive(LT, 1, 64'hC008000000000000, 64'h3FF0000000000000, 64'd1, 0, "R2 lt d -3<1");
    drive(LE, 1, 64'h3FF0000000000000, 64'h3FF0000000000000, 64'd1, 0, "R2 le d 1<=1");
    drive(EQ, 1, 64'h3FF0000000000000, 64'h3FF0000000000000, 64'd1, 0, "R2 eq d");
    drive(LT, 0, 64'hFF800000, 64'hBF800000, 64'd1, 0, "R2 lt s -inf<-1");
    // R3
    drive(LT, 0, 64'h7FC00000, 64'h3F800000, 64'd0, 1, "R3 lt qnan");
    drive(LE, 1, 64'h3FF0000000000000, 64'h7FF0000000000001, 64'd0, 1, "R3 le snan");
    // R4
    drive(EQ, 0, 64'h7FC00000, 64'h7FC00000, 64'd0, 0, "R4 eq qnan");
    drive(EQ, 1, 64'h7FF0000000000001, 64'h3FF0000000000000, 64'd0, 1, "R4 eq snan");
    // R5
    drive(EQ, 0, 64'h80000000, 64'h00000000, 64'd1, 0, "R5 eq zeros");
    drive(LT, 0, 64'h80000000, 64'h00000000, 64'd0, 0, "R5 lt zeros");
    drive(LE, 0, 64'h00000000, 64'h80000000, 64'd1, 0, "R5 le zeros");
    // R6
    drive(MN, 0, 64'h3F800000, 64'h7F800001, 64'h3F800000, 1, "R6 min snan b");
    drive(MX, 0, 64'h7F800001, 64'h40000000, 64'h40000000, 1, "R6 max snan a");
    drive(MN, 1, 64'h7FF0000000000001, 64'h7FF0000000000002, 64'h7FF0000000000001, 1, "R6 min both snan");
    // R7
    drive(MX, 0, 64'h7FC00000, 64'hBF800000, 64'hBF800000, 0, "R7 max qnan a");
    drive(MN, 1, 64'h4000000000000000, 64'h7FF8000000000000, 64'h4000000000000000, 0, "R7 min qnan b");
    // R8
    drive(MX, 0, 64'hFFC00005, 64'h7FC00003, 64'h7FC00000, 0, "R8 canon s");
    drive(MN, 1, 64'hFFF8000000000007, 64'h7FF8000000000009, 64'h7FF8000000000000, 0, "R8 canon d");
    // R9
    drive(MN, 0, 64'h00000000, 64'h80000000, 64'h80000000, 0, "R9 min zeros");
    drive(MX, 0, 64'h80000000, 64'h00000000, 64'h00000000, 0, "R9 max zeros");
    drive(MN, 1, 64'h4000000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 0, "R9 min d");
    drive(MX, 1, 64'hC008000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 0, "R9 max d");
    // R10
    drive(CL, 0, 64'hFF800000, 64'd0, 64'h001, 0, "R10 -inf");
    drive(CL, 0, 64'hBF800000, 64'd0, 64'h002, 0, "R10 -norm");
    drive(CL, 0, 64'h80000001, 64'd0, 64'h004, 0, "R10 -sub");
    drive(CL, 0, 64'h80000000, 64'd0, 64'h008, 0, "R10 -zero");
    drive(CL, 0, 64'h00000000, 64'd0, 64'h010, 0, "R10 +zero");
    drive(CL, 0, 64'h00000001, 64'd0, 64'h020, 0, "R10 +sub");
    drive(CL, 0, 64'h3F800000, 64'd0, 64'h040, 0, "R10 +norm");
    drive(CL, 0, 64'h7F800000, 64'd0, 64'h080, 0, "R10 +inf");
    drive(CL, 0, 64'h7F800001, 64'd0, 64'h100, 0, "R10 snan");
    drive(CL, 0, 64'h7FC00000, 64'd0, 64'h200, 0, "R10 qnan");
    drive(CL, 1, 64'h7FF0000000000001, 64'd0, 64'h100, 0, "R10 snan d");
    drive(CL, 1, 64'h8000000000000000, 64'd0, 64'h008, 0, "R10 -zero d");
    // R11
    drive(LT, 0, 64'hFFFFFFFF3F800000, 64'h0000000040000000, 64'd1, 0, "R11 lt upper ignored");
    drive(MN, 0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 64'h3F800000, 0, "R11 min zero-ext");
    drive(CL, 0, 64'h7FF0000100000000, 64'd0, 64'h010, 0, "R11 class upper ignored");
    // R1 unused codes
    drive(3'd6, 0, 64'h3F800000, 64'h7F800001, 64'd0, 0, "R1 code 6");
    drive(3'd7, 1, 64'h7FF0000000000001, 64'd0, 64'd0, 0, "R1 code 7");
    drive(MX, 1, 64'h3FF0000000000000, 64'h4000000000000000, 64'h4000000000000000, 0, "R1 last");
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'h4000000000000000 || invalid !== 1'b0 || sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 idle hold: act v=%b r=%h q=%0d exp 0 4000000000000000 0", out_valid, result, sb_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule